// File: doc/BRIEF.md
# ISA-Style I/O Address Decoder with Shared Interrupt Gate

This block is the glue that sits between an 8-bit, ISA-style I/O bus and a 24-line parallel port core. It compares the upper address lines against a base value set by straps, hands the two lowest address lines to the core as a register index, and produces the core's chip select, its gated read and write strobes, and the enables of the bus data transceiver. The block claims four consecutive byte addresses and supports only 8-bit transfers.

It also turns the core's two interrupt requests into one shared interrupt line. The group A request appears on port C bit 3 and the group B request on port C bit 0, both active high. A strap picks one of the port C bits 2, 4 or 6 as an active-low enable, or "none", which blocks every interrupt. A second strap picks one of six request lines (IRQ3, IRQ4, IRQ5, IRQ6, IRQ7, IRQ9). The chosen line is driven high while a gated request is present and is left floating otherwise, so other boards can share it. The default setup is base 0x210 (strap 0x84), enable from PC4 and IRQ5. All straps are sampled while reset is held and stay fixed after reset is released.

Top module: `hostio_glue`

## Requirements
- R1: The core chip select (`core_cs_n`) is low exactly when address bits 9..2 equal the latched base strap and the base is not reserved. `core_rd_n` and `core_wr_n` follow `bus_rd_n` and `bus_wr_n` only while the chip select is low, and are high otherwise.
- R2: `core_reg` always equals address bits 1..0, so the block answers at base+0 through base+3.
- R3: A base strap below 0x40 (a bus address below 0x100) is reserved and never produces a match.
- R4: `xcvr_oe_n` is low only when the address matches and a read or write strobe is low. `xcvr_dir` is 1 (board drives the bus) only during a matched read and is 0 in every other case.
- R5: `base_strap`, `en_src` and `irq_pick` are captured on every clock edge while `rst_n` is low. Changes to them after reset release have no effect until the next reset.
- R6: Enable source code 0 ("none") blocks all interrupts. No interrupt line is driven, whatever port C holds.
- R7: Enable codes 1, 2 and 3 select port C bit 2, 4 and 6. A request passes only while the selected bit is 0. A 1 on that bit blocks it. The other enable bits have no effect.
- R8: The interrupt request is port C bit 3 OR port C bit 0. It is registered, so the line changes one clock after port C changes.
- R9: Pick codes 0 to 5 map to `irq_line[0..5]`, which are IRQ3, IRQ4, IRQ5, IRQ6, IRQ7 and IRQ9. Codes 6 and 7 drive no line. A line that is not picked is always high-impedance.
- R10: The picked line is driven to 1 while a gated request is present and is high-impedance otherwise. It is never driven to 0.
- R11: While reset is held, and on the first clock after it, the registered request is clear and every interrupt line is high-impedance.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| bus_addr | input | 10 | I/O bus address lines 9..0 |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| base_strap | input | 8 | Base address bits 9..2 |
| en_src | input | 2 | Interrupt enable source: 0 none, 1 PC2, 2 PC4, 3 PC6 |
| irq_pick | input | 3 | Interrupt line pick: 0..5 = IRQ3,4,5,6,7,9; 6,7 none |
| port_c | input | 8 | Port C lines from the parallel port core |
| core_cs_n | output | 1 | Core chip select, active low |
| core_rd_n | output | 1 | Gated read strobe to the core |
| core_wr_n | output | 1 | Gated write strobe to the core |
| core_reg | output | 2 | Register index to the core |
| xcvr_oe_n | output | 1 | Data transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward the bus |
| irq_line | output | 6 | Shared interrupt lines, 1 or high-impedance |

## Verification
On every cycle, the assertions check four things. Strobes never reach the core without a chip select. The transceiver never faces the bus outside a matched read. At most one interrupt line is driven, and only with a request in the previous cycle and a source other than "none". Latched straps never move while out of reset. What the assertions cannot show is the decode against the chosen base and the reserved range, the choice among the three enable bits, and the line map. The bench's reference model checks these over strap sets taken across several resets, including straps changed after release.

// File: rtl/hostio_pkg.sv
// Package: shared constants and helper for the host I/O glue.
// Assumes a 10-bit I/O address space and a byte-wide port C.
package hostio_pkg;

    // Enable source codes carried on en_src.
    typedef enum logic [1:0] {
        EN_NONE = 2'd0,
        EN_PC2  = 2'd1,
        EN_PC4  = 2'd2,
        EN_PC6  = 2'd3
    } en_src_t;

    // Port C bit used as enable gate for a given source code (code * step).
    function automatic int unsigned gate_bit(input logic [1:0] code, input int unsigned step);
        return int'(code) * step;
    endfunction

endpackage

// File: rtl/hostio_strap_latch.sv
// Module: strap sampler.
// Captures the configuration straps on every clock while reset is held and
// keeps them frozen afterwards. Assumes straps are static around reset.
module hostio_strap_latch #(
    parameter int BASE_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base_in,
    input  logic [1:0]        en_in,
    input  logic [SEL_W-1:0]  sel_in,
    output logic [BASE_W-1:0] base_q,
    output logic [1:0]        en_q,
    output logic [SEL_W-1:0]  sel_q
);

    // Load straps during reset, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= base_in;
            en_q   <= en_in;
            sel_q  <= sel_in;
        end
    end

endmodule

// File: rtl/hostio_addr_decode.sv
// Module: address decoder and transceiver control.
// Compares the upper address bits against the latched base, refuses bases
// in the reserved low range, passes the register index through, and gates
// the strobes and transceiver enables. Purely combinational.
module hostio_addr_decode #(
    parameter int ADDR_W    = 10,
    parameter int REG_W     = 2,
    parameter int RSV_LIMIT = 'h100
) (
    input  logic                    [ADDR_W-1:0] addr,
    input  logic                                 rd_n,
    input  logic                                 wr_n,
    input  logic             [ADDR_W-REG_W-1:0]  base,
    output logic                                 cs_n,
    output logic                                 core_rd_n,
    output logic                                 core_wr_n,
    output logic                    [REG_W-1:0]  reg_idx,
    output logic                                 oe_n,
    output logic                                 dir
);

    localparam int BASE_W    = ADDR_W - REG_W;
    localparam int RSV_STRAP = RSV_LIMIT >> REG_W;

    logic base_ok;
    logic hit;

    // Reserved-range screen and address compare.
    always_comb begin
        base_ok = (int'(base) >= RSV_STRAP);
        hit     = base_ok && (addr[ADDR_W-1:REG_W] == base);
    end

    // Chip select, gated strobes and register index.
    always_comb begin
        cs_n      = !hit;
        core_rd_n = hit ? rd_n : 1'b1;
        core_wr_n = hit ? wr_n : 1'b1;
        reg_idx   = addr[REG_W-1:0];
    end

    // Transceiver enable and direction; read takes the direction.
    always_comb begin
        oe_n = !(hit && (!rd_n || !wr_n));
        dir  = hit && !rd_n;
    end

endmodule

// File: rtl/hostio_irq_gate.sv
// Module: interrupt gate and shared-line driver.
// ORs the two group requests from port C, gates them with an active-low
// enable bit chosen by strap, registers the result and drives the picked
// line high through a tristate output. Assumes sel values past the line
// count mean "no line".
module hostio_irq_gate #(
    parameter int PORT_W  = 8,
    parameter int NUM_IRQ = 6,
    parameter int SEL_W   = 3,
    parameter int REQ_A   = 3,
    parameter int REQ_B   = 0,
    parameter int EN_STEP = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PORT_W-1:0]  port_c,
    input  logic [1:0]         en_src,
    input  logic [SEL_W-1:0]   sel,
    output logic               req_q,
    output logic [NUM_IRQ-1:0] irq_line
);

    import hostio_pkg::*;

    logic gate_open;
    logic req_raw;

    // Pick the enable bit; "none" keeps the gate shut.
    always_comb begin
        gate_open = 1'b0;
        for (int k = 1; k < 4; k++) begin
            if (en_src == k[1:0]) begin
                gate_open = !port_c[gate_bit(k[1:0], EN_STEP)];
            end
        end
        req_raw = (port_c[REQ_A] || port_c[REQ_B]) && gate_open;
    end

    // Register the gated request; cleared during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_raw;
    end

    // One tristate driver per shared line.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign irq_line[i] = (req_q && (int'(sel) == i)) ? 1'b1 : 1'bz;
    end

endmodule

// File: rtl/hostio_glue.sv
// Module: top of the host I/O glue.
// Ties the strap sampler, address decoder and interrupt gate together.
// Assumes 8-bit transfers only and a synchronous active-low reset.
module hostio_glue #(
    parameter int ADDR_W    = 10,
    parameter int REG_W     = 2,
    parameter int PORT_W    = 8,
    parameter int NUM_IRQ   = 6,
    parameter int SEL_W     = 3,
    parameter int RSV_LIMIT = 'h100
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_rd_n,
    input  logic                      bus_wr_n,
    input  logic [ADDR_W-REG_W-1:0]   base_strap,
    input  logic [1:0]                en_src,
    input  logic [SEL_W-1:0]          irq_pick,
    input  logic [PORT_W-1:0]         port_c,
    output logic                      core_cs_n,
    output logic                      core_rd_n,
    output logic                      core_wr_n,
    output logic [REG_W-1:0]          core_reg,
    output logic                      xcvr_oe_n,
    output logic                      xcvr_dir,
    output logic [NUM_IRQ-1:0]        irq_line
);

    localparam int BASE_W = ADDR_W - REG_W;

    logic [BASE_W-1:0] base_q;
    logic [1:0]        en_q;
    logic [SEL_W-1:0]  sel_q;
    logic              req_q;

    hostio_strap_latch #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_straps (
        .clk(clk), .rst_n(rst_n),
        .base_in(base_strap), .en_in(en_src), .sel_in(irq_pick),
        .base_q(base_q), .en_q(en_q), .sel_q(sel_q)
    );

    hostio_addr_decode #(.ADDR_W(ADDR_W), .REG_W(REG_W), .RSV_LIMIT(RSV_LIMIT)) u_dec (
        .addr(bus_addr), .rd_n(bus_rd_n), .wr_n(bus_wr_n), .base(base_q),
        .cs_n(core_cs_n), .core_rd_n(core_rd_n), .core_wr_n(core_wr_n),
        .reg_idx(core_reg), .oe_n(xcvr_oe_n), .dir(xcvr_dir)
    );

    hostio_irq_gate #(.PORT_W(PORT_W), .NUM_IRQ(NUM_IRQ), .SEL_W(SEL_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .port_c(port_c), .en_src(en_q), .sel(sel_q),
        .req_q(req_q), .irq_line(irq_line)
    );

endmodule

// File: rtl/hostio_glue_chk.sv
// Module: property checker bound to the host I/O glue top.
module hostio_glue_chk #(
    parameter int NUM_IRQ = 6,
    parameter int BASE_W  = 8,
    parameter int PORT_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_rd_n,
    input logic               core_cs_n,
    input logic               core_rd_n,
    input logic               core_wr_n,
    input logic               xcvr_dir,
    input logic [PORT_W-1:0]  port_c,
    input logic [NUM_IRQ-1:0] irq_line,
    input logic [BASE_W-1:0]  base_q,
    input logic [1:0]         en_q
);

    logic [NUM_IRQ-1:0] drv;

    // Which lines are actively driven high.
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) drv[i] = (irq_line[i] === 1'b1);
    end

    // R1
    strobe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_cs_n |-> (core_rd_n && core_wr_n));

    // R4
    xcvr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xcvr_dir |-> (!core_cs_n && !bus_rd_n));

    // R9
    single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv));

    // R5
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(base_q) && $stable(en_q));

    // R6
    none_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 2'd0) |=> (drv == '0));

    // R8
    req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && (drv != '0)) |-> ($past(port_c[3]) || $past(port_c[0])));

endmodule

bind hostio_glue hostio_glue_chk #(.NUM_IRQ(NUM_IRQ), .BASE_W(ADDR_W - REG_W), .PORT_W(PORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd_n(bus_rd_n), .core_cs_n(core_cs_n),
    .core_rd_n(core_rd_n), .core_wr_n(core_wr_n), .xcvr_dir(xcvr_dir),
    .port_c(port_c), .irq_line(irq_line), .base_q(base_q), .en_q(en_q)
);

// File: tb/hostio_glue_test.sv
// Bench: behavioural reference model compared on every clock.
module hostio_glue_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] bus_addr;
    logic       bus_rd_n, bus_wr_n;
    logic [7:0] base_strap;
    logic [1:0] en_src;
    logic [2:0] irq_pick;
    logic [7:0] port_c;
    logic       core_cs_n, core_rd_n, core_wr_n, xcvr_oe_n, xcvr_dir;
    logic [1:0] core_reg;
    logic [5:0] irq_line;

    int errs = 0;
    int checks = 0;
    bit done = 0;
    string tag = "R11";

    always #10 clk = ~clk;

    hostio_glue uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .base_strap(base_strap), .en_src(en_src),
        .irq_pick(irq_pick), .port_c(port_c), .core_cs_n(core_cs_n),
        .core_rd_n(core_rd_n), .core_wr_n(core_wr_n), .core_reg(core_reg),
        .xcvr_oe_n(xcvr_oe_n), .xcvr_dir(xcvr_dir), .irq_line(irq_line)
    );

    // Reference model state.
    int m_base = 0, m_en = 0, m_pick = 7;
    bit m_req = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_base = base_strap; m_en = en_src; m_pick = irq_pick; m_req = 0;
        end else begin
            bit open;
            int eb;
            eb = m_en * 2;
            open = (m_en != 0) && (port_c[eb] == 1'b0);
            m_req = open && (port_c[3] || port_c[0]);
        end
    end

    task automatic cmp(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic cyc();
        bit hit;
        logic [5:0] ei;
        @(posedge clk);
        #5;
        hit = (m_base >= 'h40) && (int'(bus_addr) / 4 == m_base);
        for (int i = 0; i < 6; i++) ei[i] = (m_req && m_pick == i) ? 1'b1 : 1'bz;
        cmp("cs_n", {7'd0, core_cs_n}, {7'd0, !hit});
        cmp("rd_n", {7'd0, core_rd_n}, {7'd0, hit ? bus_rd_n : 1'b1});
        cmp("wr_n", {7'd0, core_wr_n}, {7'd0, hit ? bus_wr_n : 1'b1});
        cmp("reg",  {6'd0, core_reg}, {6'd0, bus_addr[1:0]});
        cmp("oe_n", {7'd0, xcvr_oe_n}, {7'd0, !(hit && (!bus_rd_n || !bus_wr_n))});
        cmp("dir",  {7'd0, xcvr_dir}, {7'd0, hit && !bus_rd_n});
        cmp("irq",  {2'd0, irq_line}, {2'd0, ei});
    endtask

    task automatic do_reset(input logic [7:0] b, input logic [1:0] e, input logic [2:0] p);
        tag = "R11";
        rst_n = 0; base_strap = b; en_src = e; irq_pick = p;
        port_c = 8'h09; bus_rd_n = 1; bus_wr_n = 1;
        repeat (3) cyc();
        rst_n = 1; port_c = 8'h00;
        cyc();
    endtask

    task automatic access(input int a, input bit rd, input bit wr);
        bus_addr = a[9:0]; bus_rd_n = !rd; bus_wr_n = !wr;
        cyc();
        bus_rd_n = 1; bus_wr_n = 1;
    endtask

    initial begin
        bus_addr = 0;
        do_reset(8'h84, 2'd2, 3'd2);

        // R1 R2 R4: window around base 0x210 with reads, writes, idle.
        tag = "R1/R2/R4 sweep";
        for (int a = 'h20C; a < 'h218; a++) begin
            access(a, 1, 0); access(a, 0, 1); access(a, 0, 0);
        end
        tag = "R4 both strobes";
        access('h211, 1, 1);

        // R5: straps changed after release have no effect.
        tag = "R5";
        base_strap = 8'h9E; en_src = 2'd0; irq_pick = 3'd5;
        access('h278, 1, 0); access('h213, 1, 0);

        // R8 R10: requests from PC3 and PC0 reach IRQ5 a clock later.
        tag = "R8";
        port_c = 8'h08; cyc(); cyc();
        port_c = 8'h01; cyc(); cyc();
        tag = "R10";
        port_c = 8'h00; cyc(); cyc();
        // R7: the PC4 gate closes; other enable bits are ignored.
        tag = "R7";
        port_c = 8'h18; cyc(); cyc();
        port_c = 8'h4D; cyc(); cyc();

        // R6 R3: enable "none" and a reserved base.
        do_reset(8'h08, 2'd0, 3'd5);
        tag = "R6";
        port_c = 8'h09; cyc(); cyc();
        tag = "R3";
        access('h020, 1, 0); access('h023, 0, 1);

        // R9: unused pick code drives nothing, then each line in turn.
        do_reset(8'hFF, 2'd1, 3'd6);
        tag = "R9 none";
        port_c = 8'h08; cyc(); cyc();
        for (int p = 0; p < 6; p++) begin
            do_reset(8'hC0, 2'd3, p[2:0]);
            tag = "R9 map";
            port_c = 8'h01; cyc(); cyc();
            tag = "R7 pc6";
            port_c = 8'h41; cyc(); cyc();
        end
        tag = "R1 high base";
        access('h300, 1, 0); access('h3FF, 0, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule